// File: doc/BRIEF.md
# VCO Band-Select Calibrator

This block calibrates a wideband LC oscillator that has a switched capacitor bank. It picks the bank code before the phase-locked loop takes over. A start pulse opens the loop and loads the mid-scale trial code. Each trial then runs in three steps. First the block waits a programmable number of reference cycles so the oscillator can settle. Next it counts rising edges of the divided oscillator clock over a programmable window of reference cycles. Last, it compares that count with a programmed target and decides one code bit. The bits are resolved from the most significant one down, so seven trials give the final 7-bit band.

A larger code adds capacitance and so lowers the frequency. A count above the target therefore means the oscillator is still too fast, and the trial bit stays set. After the last decision the block holds the chosen code. It raises its done flag and its loop-enable output in the same cycle, and the closed loop then does the fine tuning. The divided clock is asynchronous to the reference clock, so it is synchronised before edges are detected. The edge counter saturates instead of wrapping.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, band_code is 64 (only bit 6 set), and cal_done and loop_en are both low.
- R2: The cycle after cal_start is sampled high, band_code is 64, and cal_done and loop_en are low.
- R3: One trial takes max(settle_cycles,1) + max(window_cycles,1) + 1 reference cycles. cal_done rises exactly 7 trials after the clock edge that sampled cal_start.
- R4: At the end of each trial, the trial bit stays 1 when the edge count is strictly greater than target, and is cleared otherwise. The next lower bit is then set to 1 for the next trial, so after the first trial band_code is 96 or 32.
- R5: The final band_code is the largest code whose measured count exceeds target. It is 127 when every code exceeds target, and 0 when none does.
- R6: loop_en stays low during the whole search and rises in the same cycle as cal_done. Both then stay high, and band_code holds its value until the next cal_start.
- R7: A cal_start during a running search drops the search in progress and starts again from code 64, with the full seven-trial timing.
- R8: The edge count stops at its maximum value 2^CNT_W-1 and never wraps, so a count beyond the range still compares as greater than any target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start or restart calibration (one-cycle pulse) |
| settle_cycles | input | TMR_W | Settling wait per trial, in reference cycles (0 acts as 1) |
| window_cycles | input | TMR_W | Counting window per trial, in reference cycles (0 acts as 1) |
| target | input | CNT_W | Target edge count for the window |
| fb_clk | input | 1 | Divided oscillator clock, asynchronous |
| band_code | output | CODE_W | Capacitor-bank code driven to the oscillator |
| cal_done | output | 1 | Calibration finished, code held |
| loop_en | output | 1 | Closed-loop fine tuning enabled |

## Verification
The first trial code is due on the edge that samples cal_start. Each decided bit appears settle+window+1 edges after its trial began, and cal_done with loop_en appears seven trials after the start edge. The bench works out these edge counts from the programmed settle and window values. It waits exactly that many rising edges and samples on the following falling edge. It samples once one edge before cal_done is due, to check the flag is still low, and once on the due edge. The oscillator model is a phase accumulator whose rate drops with the code. Targets sit at least one count away from the model's ideal count at each deciding code, so the one-edge uncertainty of synchronising an asynchronous clock cannot change a decision.

// File: rtl/vco_cal_pkg.sv
package vco_cal_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETTLE  = 3'd1,
      ST_MEASURE = 3'd2,
      ST_DECIDE  = 3'd3,
      ST_LOCKED  = 3'd4
   } cal_state_t;
endpackage

// File: rtl/vco_cal_edge_cnt.sv
module vco_cal_edge_cnt #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fb_clk,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic [CNT_W-1:0]       count_inc;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign count_inc = (count == CMAX) ? count : count + 1'b1;
      end else begin : g_wrap
         assign count_inc = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], fb_clk};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          count <= '0;
      else if (clr)        count <= '0;
      else if (en && rise) count <= count_inc;
   end
endmodule

// File: rtl/vco_cal_timer.sv
module vco_cal_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] cycles,
   output logic             expired
);
   logic [TMR_W-1:0] remain_q;
   logic [TMR_W-1:0] load_val;

   assign load_val = (cycles == '0) ? '0 : cycles - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= '0;
      else if (load)             remain_q <= load_val;
      else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
   end

   assign expired = (remain_q == '0);
endmodule

// File: rtl/vco_cal_sar.sv
module vco_cal_sar #(
   parameter int CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              decide,
   input  logic              keep,
   output logic [CODE_W-1:0] code,
   output logic              last
);
   localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] mask_q;
   logic [CODE_W-1:0] kept;

   assign kept = keep ? code : (code & ~mask_q);
   assign last = mask_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= MID;
         mask_q <= MID;
      end else if (init) begin
         code   <= MID;
         mask_q <= MID;
      end else if (decide) begin
         code   <= kept | (mask_q >> 1);
         mask_q <= mask_q >> 1;
      end
   end
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
   parameter int CODE_W      = 7,
   parameter int CNT_W       = 16,
   parameter int TMR_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic [TMR_W-1:0]  settle_cycles,
   input  logic [TMR_W-1:0]  window_cycles,
   input  logic [CNT_W-1:0]  target,
   input  logic              fb_clk,
   output logic [CODE_W-1:0] band_code,
   output logic              cal_done,
   output logic              loop_en
);
   import vco_cal_pkg::*;

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
      if (CNT_W < 2 || TMR_W < 2) begin : g_bad_width
         $error("CNT_W and TMR_W must be at least 2");
      end
   endgenerate

   cal_state_t       state_q;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_cycles;
   logic             tmr_expired;
   logic             cnt_clr;
   logic             cnt_en;
   logic [CNT_W-1:0] meas_cnt;
   logic             sar_decide;
   logic             sar_last;
   logic             keep_bit;

   assign keep_bit   = meas_cnt > target;
   assign cnt_en     = (state_q == ST_MEASURE);
   assign sar_decide = (state_q == ST_DECIDE) && !cal_start;

   always_comb begin
      tmr_load   = 1'b0;
      tmr_cycles = settle_cycles;
      cnt_clr    = 1'b0;
      if (cal_start) begin
         tmr_load = 1'b1;
      end else if (state_q == ST_SETTLE && tmr_expired) begin
         tmr_load   = 1'b1;
         tmr_cycles = window_cycles;
         cnt_clr    = 1'b1;
      end else if (state_q == ST_DECIDE && !sar_last) begin
         tmr_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cal_done <= 1'b0;
         loop_en  <= 1'b0;
      end else if (cal_start) begin
         state_q  <= ST_SETTLE;
         cal_done <= 1'b0;
         loop_en  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_SETTLE:  if (tmr_expired) state_q <= ST_MEASURE;
            ST_MEASURE: if (tmr_expired) state_q <= ST_DECIDE;
            ST_DECIDE: begin
               if (sar_last) begin
                  state_q  <= ST_LOCKED;
                  cal_done <= 1'b1;
                  loop_en  <= 1'b1;
               end else begin
                  state_q <= ST_SETTLE;
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   vco_cal_timer #(.TMR_W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .cycles  (tmr_cycles),
      .expired (tmr_expired)
   );

   vco_cal_edge_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .SATURATE(1'b1)) u_edge_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .fb_clk (fb_clk),
      .clr    (cnt_clr),
      .en     (cnt_en),
      .count  (meas_cnt)
   );

   vco_cal_sar #(.CODE_W(CODE_W)) u_sar (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (cal_start),
      .decide (sar_decide),
      .keep   (keep_bit),
      .code   (band_code),
      .last   (sar_last)
   );
endmodule

// File: rtl/vco_band_cal_chk.sv
module vco_band_cal_chk
   import vco_cal_pkg::*;
#(
   parameter int CODE_W = 7,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cal_start,
   input logic [CODE_W-1:0] band_code,
   input logic              cal_done,
   input logic              loop_en,
   input cal_state_t        st,
   input logic              sar_last,
   input logic [CNT_W-1:0]  cnt_val,
   input logic              cnt_en
);
   localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CNT_W-1:0]  CMAX = {CNT_W{1'b1}};

   // R2
   restart_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> (band_code == MID) && !cal_done && !loop_en);

   // R6
   search_loop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SETTLE || st == ST_MEASURE || st == ST_DECIDE) |-> !loop_en && !cal_done);

   // R6
   lock_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DECIDE && sar_last && !cal_start) |=> cal_done && loop_en);

   // R6
   hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !cal_start) |=> $stable(band_code) && cal_done && loop_en);

   // R4
   code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_start && st != ST_DECIDE) |=> $stable(band_code));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cnt_val == CMAX) |=> cnt_val == CMAX);
endmodule

bind vco_band_cal vco_band_cal_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cal_start (cal_start),
   .band_code (band_code),
   .cal_done  (cal_done),
   .loop_en   (loop_en),
   .st        (state_q),
   .sar_last  (sar_last),
   .cnt_val   (meas_cnt),
   .cnt_en    (cnt_en)
);

// File: tb/vco_band_cal_tb.sv
module vco_band_cal_tb;
   localparam int CODE_W = 7;
   localparam int CNT_W  = 9;
   localparam int TMR_W  = 16;
   localparam int ACC_W  = 14;
   localparam int WIN    = 2048;
   localparam int N_VEC  = 5;
   // settle, target, expected final code; ideal count per code = 450 - 3*code at WIN
   localparam int TAB_S[N_VEC] = '{16, 5, 1, 30, 8};
   localparam int TAB_T[N_VEC] = '{328, 418, 148, 0, 460};
   localparam int TAB_E[N_VEC] = '{40, 10, 100, 127, 0};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_start = 1'b0;
   logic [TMR_W-1:0]  settle_cycles = '0;
   logic [TMR_W-1:0]  window_cycles = '0;
   logic [CNT_W-1:0]  target = '0;
   logic              fb_clk;
   logic [CODE_W-1:0] band_code;
   logic              cal_done;
   logic              loop_en;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   // oscillator model: higher code, lower rate
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] rate;
   assign rate   = ACC_W'(3600 - 24 * int'(band_code));
   assign fb_clk = acc_q[ACC_W-1];
   always_ff @(posedge clk) acc_q <= rst_n ? acc_q + rate : '0;

   vco_band_cal #(.CODE_W(CODE_W), .CNT_W(CNT_W), .TMR_W(TMR_W)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cal_start     (cal_start),
      .settle_cycles (settle_cycles),
      .window_cycles (window_cycles),
      .target        (target),
      .fb_clk        (fb_clk),
      .band_code     (band_code),
      .cal_done      (cal_done),
      .loop_en       (loop_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start(input int s, input int w, input int t);
      @(negedge clk);
      settle_cycles = TMR_W'(s);
      window_cycles = TMR_W'(w);
      target        = CNT_W'(t);
      cal_start     = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cal_start = 1'b0;
   endtask

   task automatic run_cal(input int s, input int w, input int t, input int ex, input string tag);
      int trial = s + w + 1;
      int first = (ex >= 64) ? 96 : 32;
      pulse_start(s, w, t);
      chk(band_code == 7'd64 && !cal_done && !loop_en, tag, int'(band_code), 64);
      repeat (trial) @(posedge clk);
      @(negedge clk);
      chk(band_code == CODE_W'(first), "R4 first trial code", int'(band_code), first);
      chk(!loop_en && !cal_done, "R6 loop_en low in search", int'(loop_en), 0);
      repeat (6 * trial - 1) @(posedge clk);
      @(negedge clk);
      chk(!cal_done, "R3 done not early", int'(cal_done), 0);
      @(posedge clk);
      @(negedge clk);
      chk(cal_done, "R3 done on time", int'(cal_done), 1);
      chk(loop_en, "R6 loop_en with done", int'(loop_en), 1);
      chk(band_code == CODE_W'(ex), "R5 final code", int'(band_code), ex);
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(band_code == CODE_W'(ex) && cal_done && loop_en, "R6 code held", int'(band_code), ex);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(band_code == 7'd64, "R1 reset code", int'(band_code), 64);
      chk(!cal_done && !loop_en, "R1 reset flags", int'(cal_done) + int'(loop_en), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int i = 0; i < N_VEC; i++) begin
         run_cal(TAB_S[i], WIN, TAB_T[i], TAB_E[i], "R2 start code");
      end

      // R7: restart in the middle of a search (code is 40 during trial 4)
      pulse_start(12, WIN, 328);
      repeat (3 * (12 + WIN + 1) + 5) @(posedge clk);
      @(negedge clk);
      chk(band_code != 7'd64, "R7 mid-search code", int'(band_code), 40);
      run_cal(12, WIN, 328, 40, "R7 restart to 64");

      // R8: window long enough that code 64 counts past 511; saturated value stays above 500
      run_cal(4, 2 * WIN, 500, 66, "R8 start code");

      // R3: zero settle and window act as one cycle each, so the search ends after 21 cycles
      pulse_start(0, 0, 0);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(!cal_done, "R3 zero window not early", int'(cal_done), 0);
      @(posedge clk);
      @(negedge clk);
      chk(cal_done && loop_en, "R3 zero window timing", int'(cal_done), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule